// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of an audio controller into one 32-bit status word and one interrupt output. The controller-level sources (the response-ring interrupt flag, the response-ring overrun flag, and the codec state-change register masked by a wake-enable vector) fold into a single status bit 30. The per-stream buffer-completion flags map one-to-one onto status bits 0 to 7. Bit 31 summarises the status word: it is set when any status bit is also enabled in the interrupt-control register.

The block holds two small registers of its own. The first is the interrupt-control word, which has byte-masked writes and keeps only its architected bits. The second is the 15-bit codec state-change register, which codecs set through a pulse vector and software clears by writing ones. A mode input selects how the interrupt leaves the block. In level mode it is a registered level. In message mode it is a one-cycle pulse sent when the interrupt condition rises, and nothing is sent when the condition falls.

Top module: `aic_top`

## Requirements
- R1: While reset is held and in the first cycle after it, the status word, both interrupt outputs, the control register and the state-change register all read zero.
- R2: Status bit 30 is 1 when the ring interrupt flag is 1, or the ring overrun flag is 1, or any state-change bit ANDed with its wake-enable bit is 1. A flag input appears on the status word one clock after it is applied.
- R3: Status bits 0 to 7 equal the buffer-completion flags of streams 0 to 7, one clock after they are applied. Status bits 8 to 29 always read 0.
- R4: Status bit 31 is 1 exactly when status bits 30..0 ANDed with control bits 30..0 are nonzero.
- R5: Writing the control register (write strobe with select 0) updates only the bytes whose byte-mask bit is 1. It holds only the bits in mask 0xC00000FF; all other bits read 0. Bit 31 is the global enable and bit 30 enables status bit 30. Without a write, the control register keeps its value.
- R6: Each state-change bit is set by a one in the set vector. It is cleared by a write with select 1 that carries a 1 in that bit position and whose byte-mask bit is 1 (byte 0 covers bits 7..0 and byte 1 covers bits 14..8). When a set and a clear of the same bit fall in the same cycle, the set wins.
- R7: In level mode (mode input 0), the level output equals status bit 31 AND control bit 31, in the same cycle as the status word. The pulse output stays 0.
- R8: In message mode (mode input 1), the level output stays 0. The pulse output is 1 for exactly one cycle when the condition (status bit 31 AND control bit 31) goes from 0 to 1. A condition that stays high, or that falls, sends no further pulse.
- R9: Switching from level to message mode while the condition is already true sends no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_irq_i | input | 1 | Response-ring interrupt flag |
| ring_ovr_i | input | 1 | Response-ring overrun flag |
| chg_set_i | input | 15 | Codec state-change set pulses |
| wake_en_i | input | 15 | Wake-enable mask for state-change bits |
| strm_done_i | input | 8 | Per-stream buffer-completion flags |
| msg_mode_i | input | 1 | 0 = level signalling, 1 = message pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = control register, 1 = state-change clear |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte mask of the write |
| ctrl_o | output | 32 | Interrupt-control register value |
| chg_o | output | 15 | Codec state-change register value |
| int_status_o | output | 32 | Registered interrupt status word |
| irq_level_o | output | 1 | Level interrupt |
| irq_msg_o | output | 1 | One-cycle message pulse |

## Verification
Ring flags and stream flags reach the status word and the outputs one clock after they are applied. A change that passes through the control or state-change register first needs a second clock: one clock to update the register and one to register the recomputed status. The bench drives every input on the falling edge and samples on a later falling edge, with the number of rising edges in between matching the path's latency. In message mode it samples on two consecutive falling edges, to confirm that the pulse lasts one cycle and is not repeated.

// File: rtl/aic_pkg.sv
package aic_pkg;
   localparam int          AIC_DATA_W   = 32;
   localparam logic [31:0] AIC_CTRL_MSK = 32'hC000_00FF;
   localparam int          AIC_GIE_BIT  = 31;
   localparam int          AIC_CTL_BIT  = 30;

   typedef enum logic {
      AIC_SEL_CTRL = 1'b0,
      AIC_SEL_CHG  = 1'b1
   } aic_sel_e;
endpackage

// File: rtl/aic_ctrl_reg.sv
module aic_ctrl_reg #(
   parameter int          W    = 32,
   parameter logic [31:0] MASK = 32'hC000_00FF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [W-1:0]   wr_data,
   input  logic [W/8-1:0] wr_be,
   output logic [W-1:0]   ctrl_q
);
   localparam int NBYTES = W / 8;

   if (W % 8 != 0) begin : g_bad_w
      $error("aic_ctrl_reg: W must be a whole number of bytes");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            ctrl_q[b*8 +: 8] <= '0;
         else if (wr_en && wr_be[b])
            ctrl_q[b*8 +: 8] <= wr_data[b*8 +: 8] & MASK[b*8 +: 8];
      end
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_q)); // R5
endmodule

// File: rtl/aic_chg_reg.sv
module aic_chg_reg #(
   parameter int W = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         set_vec,
   input  logic                 wr_en,
   input  logic [W-1:0]         wr_data,
   input  logic [(W+7)/8-1:0]   wr_be,
   output logic [W-1:0]         chg_q
);
   logic [W-1:0] clr_vec;

   if (W > 16) begin : g_bad_w
      $error("aic_chg_reg: state-change width limited to two bytes");
   end

   for (genvar i = 0; i < W; i++) begin : g_clr
      assign clr_vec[i] = wr_en & wr_be[i/8] & wr_data[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) chg_q <= '0;
      else        chg_q <= (chg_q & ~clr_vec) | set_vec;
   end

   AST_CHG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((chg_q & $past(clr_vec & ~set_vec)) == '0)); // R6
   AST_CHG_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((chg_q & $past(set_vec)) == $past(set_vec))); // R6
endmodule

// File: rtl/aic_merge.sv
module aic_merge #(
   parameter int NUM_STREAMS = 8,
   parameter int CODEC_W     = 15,
   parameter int W           = 32
) (
   input  logic                   ring_irq,
   input  logic                   ring_ovr,
   input  logic [CODEC_W-1:0]     chg,
   input  logic [CODEC_W-1:0]     wake_en,
   input  logic [NUM_STREAMS-1:0] strm_done,
   input  logic [W-1:0]           ctrl,
   output logic [W-1:0]           sts
);
   localparam int CTL_BIT = W - 2;

   if (NUM_STREAMS > W - 2) begin : g_bad_n
      $error("aic_merge: too many streams for the status word");
   end

   logic [W-2:0] low;

   always_comb begin
      low                  = '0;
      low[NUM_STREAMS-1:0] = strm_done;
      low[CTL_BIT]         = ring_irq | ring_ovr | (|(chg & wake_en));
      sts                  = {(|(low & ctrl[W-2:0])), low};
   end
endmodule

// File: rtl/aic_signal.sv
module aic_signal #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sts_comb,
   input  logic         gie,
   input  logic         msg_mode,
   output logic [W-1:0] sts_q,
   output logic         irq_level_q,
   output logic         irq_msg_q
);
   logic cond;
   logic cond_d;

   assign cond = sts_comb[W-1] & gie;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q       <= '0;
         cond_d      <= 1'b0;
         irq_level_q <= 1'b0;
         irq_msg_q   <= 1'b0;
      end else begin
         sts_q       <= sts_comb;
         cond_d      <= cond;
         irq_level_q <= cond & ~msg_mode;
         irq_msg_q   <= cond & ~cond_d & msg_mode;
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_msg_q |=> !irq_msg_q); // R8
   AST_LEVEL_QUIET_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      $past(msg_mode) |-> !irq_level_q); // R8
   AST_LEVEL_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_level_q |-> (sts_q[W-1] && $past(gie))); // R7
endmodule

// File: rtl/aic_top.sv
module aic_top
   import aic_pkg::*;
#(
   parameter int NUM_STREAMS = 8,
   parameter int CODEC_W     = 15
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ring_irq_i,
   input  logic                   ring_ovr_i,
   input  logic [CODEC_W-1:0]     chg_set_i,
   input  logic [CODEC_W-1:0]     wake_en_i,
   input  logic [NUM_STREAMS-1:0] strm_done_i,
   input  logic                   msg_mode_i,
   input  logic                   wr_en_i,
   input  logic                   wr_sel_i,
   input  logic [31:0]            wr_data_i,
   input  logic [3:0]             wr_be_i,
   output logic [31:0]            ctrl_o,
   output logic [CODEC_W-1:0]     chg_o,
   output logic [31:0]            int_status_o,
   output logic                   irq_level_o,
   output logic                   irq_msg_o
);
   localparam int W         = AIC_DATA_W;
   localparam int CHG_BYTES = (CODEC_W + 7) / 8;

   logic         wr_ctrl;
   logic         wr_chg;
   logic [W-1:0] sts_comb;

   assign wr_ctrl = wr_en_i & (aic_sel_e'(wr_sel_i) == AIC_SEL_CTRL);
   assign wr_chg  = wr_en_i & (aic_sel_e'(wr_sel_i) == AIC_SEL_CHG);

   aic_ctrl_reg #(.W(W), .MASK(AIC_CTRL_MSK)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl),
      .wr_data(wr_data_i), .wr_be(wr_be_i), .ctrl_q(ctrl_o));

   aic_chg_reg #(.W(CODEC_W)) i_chg (
      .clk(clk), .rst_n(rst_n), .set_vec(chg_set_i), .wr_en(wr_chg),
      .wr_data(wr_data_i[CODEC_W-1:0]), .wr_be(wr_be_i[CHG_BYTES-1:0]),
      .chg_q(chg_o));

   aic_merge #(.NUM_STREAMS(NUM_STREAMS), .CODEC_W(CODEC_W), .W(W)) i_merge (
      .ring_irq(ring_irq_i), .ring_ovr(ring_ovr_i), .chg(chg_o),
      .wake_en(wake_en_i), .strm_done(strm_done_i), .ctrl(ctrl_o),
      .sts(sts_comb));

   aic_signal #(.W(W)) i_sig (
      .clk(clk), .rst_n(rst_n), .sts_comb(sts_comb),
      .gie(ctrl_o[AIC_GIE_BIT]), .msg_mode(msg_mode_i),
      .sts_q(int_status_o), .irq_level_q(irq_level_o), .irq_msg_q(irq_msg_o));

   AST_STS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sts_comb[W-2:0] & ctrl_o[W-2:0])) |=> int_status_o[W-1]); // R4
   AST_CTL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_irq_i || ring_ovr_i) |=> int_status_o[AIC_CTL_BIT]); // R2
endmodule

// File: tb/test_aic_top.sv
module test_aic_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ring_irq, ring_ovr, msg_mode, wr_en, wr_sel;
   logic [14:0] chg_set, wake_en;
   logic [7:0]  strm;
   logic [31:0] wr_data;
   logic [3:0]  wr_be;
   logic [31:0] ctrl, sts;
   logic [14:0] chg;
   logic        irq_lvl, irq_msg;

   int nchk = 0;
   int nbad = 0;

   always #10 clk = ~clk;

   aic_top i_aic_top (
      .clk(clk), .rst_n(rst_n), .ring_irq_i(ring_irq), .ring_ovr_i(ring_ovr),
      .chg_set_i(chg_set), .wake_en_i(wake_en), .strm_done_i(strm),
      .msg_mode_i(msg_mode), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .wr_be_i(wr_be), .ctrl_o(ctrl), .chg_o(chg),
      .int_status_o(sts), .irq_level_o(irq_lvl), .irq_msg_o(irq_msg));

   // {ring_irq, ring_ovr, streams[7:0], expected status} with control 0xC0000001
   localparam logic [41:0] VEC [8] = '{
      {1'b0, 1'b0, 8'h00, 32'h0000_0000},
      {1'b1, 1'b0, 8'h00, 32'hC000_0000},
      {1'b0, 1'b1, 8'h00, 32'hC000_0000},
      {1'b0, 1'b0, 8'h01, 32'h8000_0001},
      {1'b0, 1'b0, 8'h80, 32'h0000_0080},
      {1'b0, 1'b0, 8'hFF, 32'h8000_00FF},
      {1'b1, 1'b1, 8'h7E, 32'hC000_007E},
      {1'b0, 1'b0, 8'h5A, 32'h0000_005A}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_be = be;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; wr_be = '0;
   endtask

   initial begin
      #1_000_000;
      nbad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ring_irq = 0; ring_ovr = 0; msg_mode = 0; wr_en = 0; wr_sel = 0;
      chg_set = '0; wake_en = '0; strm = '0; wr_data = '0; wr_be = '0;
      repeat (3) @(negedge clk);
      chk("R1 sts", sts, 32'h0);
      chk("R1 ctrl", ctrl, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 chg", {17'h0, chg}, 32'h0);
      chk("R1 irq", {30'h0, irq_lvl, irq_msg}, 32'h0);

      // R5 control write masking and byte enables
      wr(1'b0, 32'hFFFF_FFFF, 4'hF);
      chk("R5 all bytes", ctrl, 32'hC000_00FF);
      wr(1'b0, 32'h0000_0000, 4'h1);
      chk("R5 byte0 only", ctrl, 32'hC000_0000);
      wr(1'b0, 32'h0000_0001, 4'h1);
      chk("R5 rewrite", ctrl, 32'hC000_0001);

      // table: R2 R3 R4 R7
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         ring_irq = VEC[k][41]; ring_ovr = VEC[k][40]; strm = VEC[k][39:32];
         @(negedge clk);
         chk($sformatf("R2/R3/R4 vec%0d", k), sts, VEC[k][31:0]);
         chk($sformatf("R7 vec%0d", k), {31'h0, irq_lvl}, {31'h0, VEC[k][31]});
      end
      ring_irq = 0; ring_ovr = 0; strm = 8'h01;
      wr(1'b0, 32'h0000_0000, 4'h8);
      @(negedge clk);
      chk("R7 gie off status", sts, 32'h8000_0001);
      chk("R7 gie off level", {31'h0, irq_lvl}, 32'h0);
      strm = '0;

      // R6 state-change register, R2 wake gating
      chg_set = 15'h0008;
      @(negedge clk);
      chg_set = '0;
      @(negedge clk);
      chk("R6 set", {17'h0, chg}, 32'h8);
      chk("R2 no wake", sts, 32'h0);
      wake_en = 15'h0008;
      @(negedge clk);
      chk("R2 wake", sts, 32'h4000_0000);
      wr(1'b1, 32'h0000_0008, 4'h2);
      chk("R6 wrong byte", {17'h0, chg}, 32'h8);
      @(negedge clk);
      wr_en = 1; wr_sel = 1; wr_data = 32'h8; wr_be = 4'h1; chg_set = 15'h0008;
      @(negedge clk);
      wr_en = 0; wr_data = '0; wr_be = '0; chg_set = '0;
      chk("R6 set wins", {17'h0, chg}, 32'h8);
      wr(1'b1, 32'h0000_0008, 4'h1);
      chk("R6 clear", {17'h0, chg}, 32'h0);
      @(negedge clk);
      chk("R2 cleared", sts, 32'h0);
      chg_set = 15'h4000; wake_en = 15'h4000;
      @(negedge clk);
      chg_set = '0;
      wr(1'b1, 32'h0000_4000, 4'h2);
      chk("R6 byte1 clear", {17'h0, chg}, 32'h0);
      wake_en = '0;

      // R8 message mode
      wr(1'b0, 32'h8000_0001, 4'hF);
      msg_mode = 1'b1;
      @(negedge clk);
      strm = 8'h01;
      @(negedge clk);
      chk("R8 pulse", {31'h0, irq_msg}, 32'h1);
      chk("R8 level quiet", {31'h0, irq_lvl}, 32'h0);
      @(negedge clk);
      chk("R8 one cycle", {31'h0, irq_msg}, 32'h0);
      strm = '0;
      @(negedge clk);
      chk("R8 fall silent", {31'h0, irq_msg}, 32'h0);
      @(negedge clk);
      chk("R8 fall silent2", {31'h0, irq_msg}, 32'h0);

      // R9 switch into message mode while condition held
      msg_mode = 1'b0; strm = 8'h01;
      @(negedge clk);
      chk("R9 level on", {31'h0, irq_lvl}, 32'h1);
      msg_mode = 1'b1;
      @(negedge clk);
      chk("R9 no pulse", {31'h0, irq_msg}, 32'h0);
      @(negedge clk);
      chk("R9 no pulse2", {30'h0, irq_lvl, irq_msg}, 32'h0);

      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule